// File: doc/BRIEF.md
# Peripheral Bus Interrupt Controller

This block is the device-side control slice that a peripheral needs to sit on a minicomputer-style I/O bus. It compares a 6-bit device select field against its own configured code. Only while the two match does it pass the processor's start, clear, I/O-pulse and the three data-in/data-out strobe pairs on to the device. The same match is required for its two status skip outputs.

It keeps four flags: busy, done, interrupt-disable and interrupt-request. A start strobe marks the device busy. The device's completion pulse moves it to done. A per-cycle request-enable pulse turns a finished, unmasked device into a pending interrupt request.

The block sits in a daisy chain of interrupt priority. A pending request stops the priority signal from passing downstream. When the processor acknowledges an interrupt, the device that holds the chain puts its device code on the low data lines, under a separate output enable.

Top module: `pbus_irq_ctrl`

## Requirements
- R1: In the same cycle, the outputs dev_start, dev_clear, dev_pulse, dev_din[k] and dev_dout[k] equal the matching strobe input ANDed with the select match (sel == DEV_CODE, default octal 22). With no match they are all 0.
- R2: req_en, mask_out, int_ack and io_rst take effect whatever the value of sel.
- R3: A selected start strobe sets busy and clears done on the next cycle, unless a clear or reset happens in the same cycle.
- R4: A dev_done pulse sets done and clears busy on the next cycle. If dev_done and a selected start arrive in the same cycle, done is set and busy is set.
- R5: On mask_out, int_dis takes the value of mask_bit on the next cycle. Otherwise int_dis holds its value.
- R6: On req_en, int_req loads (done AND NOT int_dis), using the flag values before the edge. Without req_en, int_req holds its value.
- R7: prio_out = prio_in AND NOT int_req, with no added latency.
- R8: ack_oe = int_ack AND prio_in AND int_req. While ack_oe is 1, ack_data carries DEV_CODE in bits [5:0] and 0 in bits [15:6]. While ack_oe is 0, ack_data is all zero.
- R9: io_rst, or a selected clear strobe, clears busy, done and int_req on the next cycle, and this takes priority over every other update. io_rst also clears int_dis. A clear strobe leaves int_dis unchanged.
- R10: skip_busy = busy AND select match, and skip_done = done AND select match.
- R11: While rst_n is low, busy, done, int_dis and int_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 6 | Device select field from the bus |
| strb_start | input | 1 | Start strobe from the processor |
| strb_clear | input | 1 | Clear strobe from the processor |
| strb_pulse | input | 1 | I/O pulse strobe from the processor |
| strb_din | input | 3 | Data-in strobes, one per transfer register |
| strb_dout | input | 3 | Data-out strobes, one per transfer register |
| io_rst | input | 1 | Bus-wide I/O reset pulse |
| req_en | input | 1 | Per-cycle request-enable pulse |
| mask_out | input | 1 | Mask-out strobe |
| mask_bit | input | 1 | This device's mask bit from the data bus |
| int_ack | input | 1 | Interrupt acknowledge |
| prio_in | input | 1 | Priority chain input from the upstream device |
| dev_done | input | 1 | Completion pulse from the device |
| dev_start | output | 1 | Gated start to the device |
| dev_clear | output | 1 | Gated clear to the device |
| dev_pulse | output | 1 | Gated I/O pulse to the device |
| dev_din | output | 3 | Gated data-in strobes |
| dev_dout | output | 3 | Gated data-out strobes |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| int_dis | output | 1 | Interrupt-disable flag |
| int_req | output | 1 | Interrupt-request flag |
| prio_out | output | 1 | Priority chain output to the downstream device |
| ack_oe | output | 1 | Output enable for the acknowledge data |
| ack_data | output | 16 | Device code during an acknowledge |
| skip_busy | output | 1 | Busy status, valid only while selected |
| skip_done | output | 1 | Done status, valid only while selected |

## Verification
The hardest state to reach from the ports is an acknowledge that this device actually wins. That takes a start, then a completion, then a request-enable while the mask flag is clear, all before anything clears the flags, and then int_ack and prio_in must be high together. The stimulus builds this sequence directly several times. It then runs a long biased pseudo-random phase: the select matches half the time, clears and resets are rare, and request-enable, prio_in and acknowledge are frequent. As a result, requests win, lose and get cancelled by masking, clear and reset in many orders. A behavioural model is compared with every output on every cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    typedef struct packed {
        logic busy;
        logic done;
        logic dis;
        logic req;
    } pbus_flags_t;
endpackage

// File: rtl/pbus_sel_decode.sv
module pbus_sel_decode #(
    parameter int              SEL_W    = 6,
    parameter logic [SEL_W-1:0] DEV_CODE = 6'o22,
    parameter int              N_XFER   = 3
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              strb_start,
    input  logic              strb_clear,
    input  logic              strb_pulse,
    input  logic [N_XFER-1:0] strb_din,
    input  logic [N_XFER-1:0] strb_dout,
    output logic              hit,
    output logic              dev_start,
    output logic              dev_clear,
    output logic              dev_pulse,
    output logic [N_XFER-1:0] dev_din,
    output logic [N_XFER-1:0] dev_dout
);
    assign hit       = (sel == DEV_CODE);
    assign dev_start = hit & strb_start;
    assign dev_clear = hit & strb_clear;
    assign dev_pulse = hit & strb_pulse;

    for (genvar k = 0; k < N_XFER; k++) begin : g_xfer
        assign dev_din[k]  = hit & strb_din[k];
        assign dev_dout[k] = hit & strb_dout[k];
    end
endmodule

// File: rtl/pbus_flags.sv
module pbus_flags
    import pbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_rst,
    input  logic        start,
    input  logic        clear,
    input  logic        dev_done,
    input  logic        mask_out,
    input  logic        mask_bit,
    input  logic        req_en,
    output pbus_flags_t flags_q
);
    pbus_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        // busy: reset/clear, then start, then completion
        if (io_rst || clear)       flags_d.busy = 1'b0;
        else if (start)            flags_d.busy = 1'b1;
        else if (dev_done)         flags_d.busy = 1'b0;
        // done: reset/clear, then completion, then start
        if (io_rst || clear)       flags_d.done = 1'b0;
        else if (dev_done)         flags_d.done = 1'b1;
        else if (start)            flags_d.done = 1'b0;
        // mask flag: only the bus reset clears it
        if (io_rst)                flags_d.dis  = 1'b0;
        else if (mask_out)         flags_d.dis  = mask_bit;
        // request: sampled from current flags on each enable pulse
        if (io_rst || clear)       flags_d.req  = 1'b0;
        else if (req_en)           flags_d.req  = flags_q.done & ~flags_q.dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/pbus_prio_ack.sv
module pbus_prio_ack #(
    parameter int               SEL_W    = 6,
    parameter int               DATA_W   = 16,
    parameter logic [SEL_W-1:0] DEV_CODE = 6'o22
) (
    input  logic              prio_in,
    input  logic              int_ack,
    input  logic              req,
    output logic              prio_out,
    output logic              ack_oe,
    output logic [DATA_W-1:0] ack_data
);
    localparam int PAD_W = DATA_W - SEL_W;

    assign prio_out = prio_in & ~req;
    assign ack_oe   = int_ack & prio_in & req;
    assign ack_data = ack_oe ? {{PAD_W{1'b0}}, DEV_CODE} : '0;
endmodule

// File: rtl/pbus_irq_ctrl.sv
module pbus_irq_ctrl #(
    parameter int               SEL_W    = 6,
    parameter int               DATA_W   = 16,
    parameter int               N_XFER   = 3,
    parameter logic [SEL_W-1:0] DEV_CODE = 6'o22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              strb_start,
    input  logic              strb_clear,
    input  logic              strb_pulse,
    input  logic [N_XFER-1:0] strb_din,
    input  logic [N_XFER-1:0] strb_dout,
    input  logic              io_rst,
    input  logic              req_en,
    input  logic              mask_out,
    input  logic              mask_bit,
    input  logic              int_ack,
    input  logic              prio_in,
    input  logic              dev_done,
    output logic              dev_start,
    output logic              dev_clear,
    output logic              dev_pulse,
    output logic [N_XFER-1:0] dev_din,
    output logic [N_XFER-1:0] dev_dout,
    output logic              busy,
    output logic              done,
    output logic              int_dis,
    output logic              int_req,
    output logic              prio_out,
    output logic              ack_oe,
    output logic [DATA_W-1:0] ack_data,
    output logic              skip_busy,
    output logic              skip_done
);
    import pbus_pkg::*;

    logic        hit;
    pbus_flags_t flags_q;

    pbus_sel_decode #(.SEL_W(SEL_W), .DEV_CODE(DEV_CODE), .N_XFER(N_XFER)) u_dec (
        .sel        (sel),
        .strb_start (strb_start),
        .strb_clear (strb_clear),
        .strb_pulse (strb_pulse),
        .strb_din   (strb_din),
        .strb_dout  (strb_dout),
        .hit        (hit),
        .dev_start  (dev_start),
        .dev_clear  (dev_clear),
        .dev_pulse  (dev_pulse),
        .dev_din    (dev_din),
        .dev_dout   (dev_dout)
    );

    pbus_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_rst   (io_rst),
        .start    (dev_start),
        .clear    (dev_clear),
        .dev_done (dev_done),
        .mask_out (mask_out),
        .mask_bit (mask_bit),
        .req_en   (req_en),
        .flags_q  (flags_q)
    );

    pbus_prio_ack #(.SEL_W(SEL_W), .DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) u_ack (
        .prio_in  (prio_in),
        .int_ack  (int_ack),
        .req      (flags_q.req),
        .prio_out (prio_out),
        .ack_oe   (ack_oe),
        .ack_data (ack_data)
    );

    assign busy      = flags_q.busy;
    assign done      = flags_q.done;
    assign int_dis   = flags_q.dis;
    assign int_req   = flags_q.req;
    assign skip_busy = hit & flags_q.busy;
    assign skip_done = hit & flags_q.done;
endmodule

// File: rtl/pbus_irq_ctrl_chk.sv
module pbus_irq_ctrl_chk #(
    parameter int               SEL_W    = 6,
    parameter int               DATA_W   = 16,
    parameter int               N_XFER   = 3,
    parameter logic [SEL_W-1:0] DEV_CODE = 6'o22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  sel,
    input logic              strb_start,
    input logic              strb_clear,
    input logic              io_rst,
    input logic              req_en,
    input logic              mask_out,
    input logic              mask_bit,
    input logic              int_ack,
    input logic              prio_in,
    input logic              dev_done,
    input logic              dev_start,
    input logic              dev_clear,
    input logic              dev_pulse,
    input logic [N_XFER-1:0] dev_din,
    input logic [N_XFER-1:0] dev_dout,
    input logic              busy,
    input logic              done,
    input logic              int_dis,
    input logic              int_req,
    input logic              prio_out,
    input logic              ack_oe,
    input logic [DATA_W-1:0] ack_data,
    input logic              skip_busy,
    input logic              skip_done
);
    logic match;
    assign match = (sel == DEV_CODE);

    assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (!dev_start && !dev_clear && !dev_pulse && dev_din == '0 && dev_dout == '0));

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (match && strb_start && !strb_clear && !io_rst) |=> busy);

    assert_completion_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_done && !io_rst && !(match && (strb_clear || strb_start))) |=> (done && !busy));

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_out && !io_rst) |=> (int_dis == $past(mask_bit)));

    assert_req_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> $past(req_en && done && !int_dis));

    assert_chain_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !prio_out);

    assert_chain_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_in && !int_req) |-> prio_out);

    assert_ack_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_oe |-> (int_ack && prio_in && int_req && ack_data[SEL_W-1:0] == DEV_CODE));

    assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_oe |-> (ack_data == '0));

    assert_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_rst |=> (!busy && !done && !int_req && !int_dis));

    assert_skip_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (!skip_busy && !skip_done));
endmodule

bind pbus_irq_ctrl pbus_irq_ctrl_chk #(
    .SEL_W(SEL_W), .DATA_W(DATA_W), .N_XFER(N_XFER), .DEV_CODE(DEV_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .strb_start(strb_start), .strb_clear(strb_clear),
    .io_rst(io_rst), .req_en(req_en), .mask_out(mask_out), .mask_bit(mask_bit),
    .int_ack(int_ack), .prio_in(prio_in), .dev_done(dev_done), .dev_start(dev_start),
    .dev_clear(dev_clear), .dev_pulse(dev_pulse), .dev_din(dev_din), .dev_dout(dev_dout),
    .busy(busy), .done(done), .int_dis(int_dis), .int_req(int_req), .prio_out(prio_out),
    .ack_oe(ack_oe), .ack_data(ack_data), .skip_busy(skip_busy), .skip_done(skip_done)
);

// File: tb/tb_pbus_irq_ctrl.sv
`timescale 1ns/1ps
module tb_pbus_irq_ctrl;
    localparam logic [5:0] CODE = 6'o22;

    logic clk = 0;
    logic rst_n = 0;
    logic [5:0] sel = 0;
    logic strb_start = 0, strb_clear = 0, strb_pulse = 0;
    logic [2:0] strb_din = 0, strb_dout = 0;
    logic io_rst = 0, req_en = 0, mask_out = 0, mask_bit = 0;
    logic int_ack = 0, prio_in = 0, dev_done = 0;
    logic dev_start, dev_clear, dev_pulse;
    logic [2:0] dev_din, dev_dout;
    logic busy, done, int_dis, int_req, prio_out, ack_oe;
    logic [15:0] ack_data;
    logic skip_busy, skip_done;

    always #2 clk = ~clk;

    pbus_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .strb_start(strb_start), .strb_clear(strb_clear),
        .strb_pulse(strb_pulse), .strb_din(strb_din), .strb_dout(strb_dout), .io_rst(io_rst),
        .req_en(req_en), .mask_out(mask_out), .mask_bit(mask_bit), .int_ack(int_ack),
        .prio_in(prio_in), .dev_done(dev_done), .dev_start(dev_start), .dev_clear(dev_clear),
        .dev_pulse(dev_pulse), .dev_din(dev_din), .dev_dout(dev_dout), .busy(busy),
        .done(done), .int_dis(int_dis), .int_req(int_req), .prio_out(prio_out),
        .ack_oe(ack_oe), .ack_data(ack_data), .skip_busy(skip_busy), .skip_done(skip_done)
    );

    int vectors = 0;
    int miscompares = 0;
    int acks_seen = 0;
    bit finished = 0;
    bit m_busy = 0, m_done = 0, m_dis = 0, m_req = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [31:0] next_rand(logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare all outputs with the model, then advance the model across one edge
    task automatic cycle();
        bit hit, clr;
        bit oe;
        #1;
        hit = (sel == CODE);
        chk("R1", "dev_start", 16'(dev_start), 16'(hit & strb_start));
        chk("R1", "dev_clear", 16'(dev_clear), 16'(hit & strb_clear));
        chk("R1", "dev_pulse", 16'(dev_pulse), 16'(hit & strb_pulse));
        chk("R1", "dev_din",   16'(dev_din),   16'(hit ? strb_din  : 3'b0));
        chk("R1", "dev_dout",  16'(dev_dout),  16'(hit ? strb_dout : 3'b0));
        chk("R3", "busy",      16'(busy),      16'(m_busy));
        chk("R4", "done",      16'(done),      16'(m_done));
        chk("R5", "int_dis",   16'(int_dis),   16'(m_dis));
        chk("R6", "int_req",   16'(int_req),   16'(m_req));
        chk("R7", "prio_out",  16'(prio_out),  16'(prio_in & !m_req));
        oe = int_ack & prio_in & m_req;
        chk("R8", "ack_oe",    16'(ack_oe),    16'(oe));
        chk("R8", "ack_data",  ack_data,       oe ? {10'b0, CODE} : 16'h0000);
        chk("R10", "skip_busy", 16'(skip_busy), 16'(hit & m_busy));
        chk("R10", "skip_done", 16'(skip_done), 16'(hit & m_done));
        if (oe) acks_seen++;
        @(posedge clk);
        clr = io_rst || (hit && strb_clear);
        begin
            bit nb, nd, ns, nr;
            nb = m_busy; nd = m_done; ns = m_dis; nr = m_req;
            if (clr) nb = 0; else if (hit && strb_start) nb = 1; else if (dev_done) nb = 0;
            if (clr) nd = 0; else if (dev_done) nd = 1; else if (hit && strb_start) nd = 0;
            if (io_rst) ns = 0; else if (mask_out) ns = mask_bit;
            if (clr) nr = 0; else if (req_en) nr = m_done && !m_dis;
            m_busy = nb; m_done = nd; m_dis = ns; m_req = nr;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        sel = 0; strb_start = 0; strb_clear = 0; strb_pulse = 0; strb_din = 0; strb_dout = 0;
        io_rst = 0; req_en = 0; mask_out = 0; mask_bit = 0; int_ack = 0; prio_in = 0; dev_done = 0;
    endtask

    // build a won acknowledge: start, finish, enable request, acknowledge
    task automatic win_ack();
        idle(); sel = CODE; strb_start = 1; cycle();          // R3
        idle(); dev_done = 1; cycle();                         // R4
        idle(); sel = 6'o05; req_en = 1; prio_in = 1; cycle(); // R2: unselected req_en
        idle(); prio_in = 1; int_ack = 1; sel = 6'o77; cycle(); // R8, R7
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        // R11: reset state while rst_n is low
        chk("R11", "busy_rst", 16'(busy), 16'h0);
        chk("R11", "done_rst", 16'(done), 16'h0);
        chk("R11", "dis_rst",  16'(int_dis), 16'h0);
        chk("R11", "req_rst",  16'(int_req), 16'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: strobes with a non-matching code must not reach the device
        idle(); sel = 6'o21; strb_start = 1; strb_clear = 1; strb_pulse = 1; strb_din = 3'b111; strb_dout = 3'b101; cycle();
        idle(); sel = CODE; strb_pulse = 1; strb_din = 3'b010; strb_dout = 3'b100; cycle();

        win_ack();
        win_ack();

        // R5 and R2: mask set from an unselected cycle blocks the next request
        idle(); sel = 6'o00; mask_out = 1; mask_bit = 1; cycle();
        idle(); sel = CODE; strb_start = 1; cycle();
        idle(); dev_done = 1; cycle();
        idle(); req_en = 1; cycle();
        chk("R6", "masked_req", 16'(int_req), 16'h0);
        // R9: clear strobe keeps the mask, reset clears it
        idle(); sel = CODE; strb_clear = 1; cycle();
        chk("R9", "clear_keeps_dis", 16'(int_dis), 16'h1);
        idle(); mask_out = 1; mask_bit = 0; cycle();
        idle(); req_en = 1; cycle();
        win_ack();
        idle(); sel = 6'o13; io_rst = 1; cycle();
        chk("R9", "reset_clears_req", 16'(int_req), 16'h0);
        // R4: completion and start together
        idle(); sel = CODE; strb_start = 1; dev_done = 1; cycle();
        chk("R4", "done_and_start_done", 16'(done), 16'h1);
        chk("R4", "done_and_start_busy", 16'(busy), 16'h1);

        // biased pseudo-random phase, model compared every cycle
        for (int n = 0; n < 20000; n++) begin
            lfsr = next_rand(lfsr);
            idle();
            sel        = lfsr[0] ? CODE : lfsr[6:1];
            strb_start = (lfsr[10:8] == 3'd0);
            strb_clear = (lfsr[15:11] == 5'd0);
            strb_pulse = lfsr[16];
            strb_din   = lfsr[19:17];
            strb_dout  = lfsr[22:20];
            io_rst     = (lfsr[30:23] == 8'd0);
            lfsr = next_rand(lfsr);
            req_en     = lfsr[1:0] != 2'b00;
            mask_out   = (lfsr[5:2] == 4'd0);
            mask_bit   = lfsr[6];
            int_ack    = lfsr[7];
            prio_in    = lfsr[9:8] != 2'b00;
            dev_done   = (lfsr[12:10] == 3'd0);
            cycle();
        end
        chk("R8", "acks_reached", 16'(acks_seen > 10), 16'h1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule